// File: doc/BRIEF.md
# Low-Power Mode and Clock-Gating Controller

This block sequences a small microcontroller through its run, sleep, stop, standby and shutdown modes. Software writes a target mode code and pulses an entry strobe. The controller then moves to that mode and drives a set of select and enable outputs: the high-speed oscillator enable, the clock source selects for the CPU, the high-performance domain, the low-power domain and a pair of general-purpose timers, the regulator drive level, and a power-off flag. The oscillators, the regulator and any glitch-free clock switching sit outside the block. Only their control codes are produced here.

On every entry into a low-power mode the controller stores the run level it was in. That level decides the clocks in STOP0, and the controller returns to it on wake. Each mode accepts its own set of wake sources. Waking from shutdown acts as a full reset and always lands in RUN0. In STANDBY1, peripherals of the low-power domain may raise an asynchronous fast-clock request. The request is synchronized and gates a clock to that peripheral alone, and the mode does not change.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, mode_cur is 0 (RUN0). The CPU and main clock selects read 3, the low-power domain and timer selects read 3, hfosc_en is 1, reg_drive is 3, pwr_off is 0, and every periph_clk_en bit is 1. Mode codes: RUN0-2 = 0-2, SLEEP0-2 = 3-5, STOP0-2 = 6-8, STANDBY0-1 = 9-10, SHUTDOWN = 11. Clock select codes: 0 gated, 1 32 kHz, 2 4 MHz, 3 32 MHz. Drive codes: 0 off, 1 low, 2 reduced, 3 full.
- R2: In a run mode, a sleep_req with mode_sel 0-2 changes the run level at the next clock edge. The CPU and main clock run at 32 MHz in RUN0 and at 32 kHz in RUN1 and RUN2. hfosc_en is 0 only in RUN2.
- R3: sleep_req is accepted only in a run mode. In a run mode, a valid low-power code takes effect at the next edge. Codes 12-15 are ignored, and so is a sleep_req made outside the run modes.
- R4: In SLEEP0/1/2 the CPU clock select is 0 and the main clock select is 3/1/1. hfosc_en is 1 in SLEEP0 and SLEEP1 and 0 in SLEEP2. reg_drive is 3.
- R5: In STOP modes the CPU and main clock selects are 0. The low-power domain select is 2 in STOP1 and 1 in STOP2, and the timers follow the domain. hfosc_en is 0 in STOP1 and STOP2. reg_drive is 2.
- R6: STOP0 entered from RUN0 gives hfosc_en 1 and domain select 2. Entered from RUN1 it gives hfosc_en 1 and select 1. Entered from RUN2 it gives hfosc_en 0 and select 1.
- R7: In both STANDBY modes the low-power domain select is 0, the timer select is 1, hfosc_en is 0 and reg_drive is 1.
- R8: In SHUTDOWN every clock select and enable is 0, reg_drive is 0 and pwr_off is 1.
- R9: A SLEEP mode wakes on irq_any or irq_lp. STOP and STANDBY modes wake only on irq_lp. irq_any alone leaves them unchanged.
- R10: A wake from SLEEP, STOP or STANDBY returns at the next edge to the run level that was active at entry.
- R11: SHUTDOWN ignores both interrupt inputs. io_wake, rst_pin_wake or dbg_wake returns it to RUN0 at the next edge, whatever the earlier run level was.
- R12: In STANDBY1, periph_clk_en[i] follows fclk_req[i] two clock edges later, and the mode does not change. In STANDBY0 the requests are ignored and periph_clk_en stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 4 | Target mode code |
| sleep_req | input | 1 | Strobe to apply mode_sel |
| irq_any | input | 1 | Any pending interrupt |
| irq_lp | input | 1 | Pending interrupt from the low-power domain |
| io_wake | input | 1 | IO wake event |
| rst_pin_wake | input | 1 | Reset pin activity |
| dbg_wake | input | 1 | Debug port activity |
| fclk_req | input | NREQ | Asynchronous fast-clock requests from peripherals |
| mode_cur | output | 4 | Current mode code |
| cpu_clk_sel | output | 2 | CPU clock select |
| mclk_sel | output | 2 | High-performance domain clock select |
| ulp_clk_sel | output | 2 | Low-power domain clock select |
| tmr_clk_sel | output | 2 | Clock select for the two timers |
| hfosc_en | output | 1 | High-speed oscillator enable |
| periph_clk_en | output | NREQ | Per-peripheral low-power clock enable |
| reg_drive | output | 2 | Regulator drive level |
| pwr_off | output | 1 | Domain power-off |

## Verification
Mode changes and wakes are due one edge after the stimulus, and every select output follows combinationally from the new mode. The bench therefore drives each stimulus on a falling edge and checks at the next falling edge. The fast-clock path is due two edges after a request changes, so the bench checks it after one edge (expecting no change yet) and again after the second. Checks that an input is ignored look at mode_cur and the enables one edge after the input has been seen.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int NREQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      mode_sel,
  input  logic            sleep_req,
  input  logic            irq_any,
  input  logic            irq_lp,
  input  logic            io_wake,
  input  logic            rst_pin_wake,
  input  logic            dbg_wake,
  input  logic [NREQ-1:0] fclk_req,
  output logic [3:0]      mode_cur,
  output logic [1:0]      cpu_clk_sel,
  output logic [1:0]      mclk_sel,
  output logic [1:0]      ulp_clk_sel,
  output logic [1:0]      tmr_clk_sel,
  output logic            hfosc_en,
  output logic [NREQ-1:0] periph_clk_en,
  output logic [1:0]      reg_drive,
  output logic            pwr_off
);
  localparam logic [3:0] RUN2 = 4'd2, SLP0 = 4'd3, SLP2 = 4'd5, STP0 = 4'd6,
                         STP1 = 4'd7, STP2 = 4'd8, SBY0 = 4'd9, SBY1 = 4'd10,
                         SHDN = 4'd11;
  localparam logic [1:0] C_OFF = 2'd0, C_32K = 2'd1, C_4M = 2'd2, C_32M = 2'd3;

  logic [3:0]      mode_q;
  logic [1:0]      lvl_q;
  logic [NREQ-1:0] req_s1, req_s2;

  wire in_run   = mode_q <= RUN2;
  wire in_sleep = mode_q >= SLP0 && mode_q <= SLP2;
  wire in_stop  = mode_q >= STP0 && mode_q <= STP2;
  wire in_stby  = mode_q == SBY0 || mode_q == SBY1;
  wire in_shdn  = mode_q == SHDN;

  wire enter     = in_run && sleep_req && mode_sel <= SHDN;
  wire wake_ret  = (in_sleep && (irq_any || irq_lp)) || ((in_stop || in_stby) && irq_lp);
  wire wake_shdn = in_shdn && (io_wake || rst_pin_wake || dbg_wake);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 4'd0;
      lvl_q  <= 2'd0;
    end else if (enter) begin
      mode_q <= mode_sel;
      lvl_q  <= mode_q[1:0];
    end else if (wake_ret) begin
      mode_q <= {2'b00, lvl_q};
    end else if (wake_shdn) begin
      mode_q <= 4'd0;
      lvl_q  <= 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= '0;
      req_s2 <= '0;
    end else begin
      req_s1 <= fclk_req;
      req_s2 <= req_s1;
    end
  end

  always_comb begin
    cpu_clk_sel = C_OFF;
    mclk_sel    = C_OFF;
    ulp_clk_sel = C_OFF;
    tmr_clk_sel = C_OFF;
    hfosc_en    = 1'b0;
    reg_drive   = 2'd0;
    case (mode_q)
      4'd0: begin cpu_clk_sel = C_32M; mclk_sel = C_32M; hfosc_en = 1'b1; end
      4'd1: begin cpu_clk_sel = C_32K; mclk_sel = C_32K; hfosc_en = 1'b1; end
      4'd2: begin cpu_clk_sel = C_32K; mclk_sel = C_32K; end
      4'd3: begin mclk_sel = C_32M; hfosc_en = 1'b1; end
      4'd4: begin mclk_sel = C_32K; hfosc_en = 1'b1; end
      4'd5: mclk_sel = C_32K;
      STP0: begin
        hfosc_en    = lvl_q != 2'd2;
        ulp_clk_sel = (lvl_q == 2'd0) ? C_4M : C_32K;
      end
      STP1: ulp_clk_sel = C_4M;
      STP2: ulp_clk_sel = C_32K;
      SBY0, SBY1: tmr_clk_sel = C_32K;
      default: ;
    endcase
    if (in_run || in_sleep) begin
      ulp_clk_sel = mclk_sel;
      tmr_clk_sel = mclk_sel;
      reg_drive   = 2'd3;
    end
    if (in_stop) begin
      tmr_clk_sel = ulp_clk_sel;
      reg_drive   = 2'd2;
    end
    if (in_stby) reg_drive = 2'd1;
  end

  assign periph_clk_en = (in_run || in_sleep || in_stop) ? {NREQ{1'b1}} :
                         (mode_q == SBY1) ? req_s2 : '0;
  assign pwr_off  = in_shdn;
  assign mode_cur = mode_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int NREQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_any,
  input logic            irq_lp,
  input logic [3:0]      mode_cur,
  input logic [1:0]      cpu_clk_sel,
  input logic [1:0]      mclk_sel,
  input logic [1:0]      ulp_clk_sel,
  input logic [1:0]      tmr_clk_sel,
  input logic            hfosc_en,
  input logic [NREQ-1:0] periph_clk_en,
  input logic [1:0]      reg_drive,
  input logic            pwr_off
);
  logic [1:0] seen_lvl;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_lvl <= 2'd0;
    else if (mode_cur <= 4'd2) seen_lvl <= mode_cur[1:0];
  end

  assert_shutdown_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cur == 4'd11 |-> (cpu_clk_sel == 2'd0 && mclk_sel == 2'd0 && ulp_clk_sel == 2'd0 &&
                           tmr_clk_sel == 2'd0 && !hfosc_en && reg_drive == 2'd0 && pwr_off));

  assert_cpu_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur >= 4'd3 && mode_cur <= 4'd10) |-> cpu_clk_sel == 2'd0);

  assert_standby_timers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == 4'd9 || mode_cur == 4'd10) |->
      (ulp_clk_sel == 2'd0 && tmr_clk_sel == 2'd1 && reg_drive == 2'd1 && !hfosc_en));

  assert_stby0_no_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cur == 4'd9 |-> periph_clk_en == '0);

  assert_deep_ignores_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur >= 4'd6 && mode_cur <= 4'd10 && !irq_lp) |=> $stable(mode_cur));

  assert_sleep_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur >= 4'd3 && mode_cur <= 4'd5 && irq_any) |=> mode_cur == {2'b00, $past(seen_lvl)});
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NREQ(NREQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_any(irq_any), .irq_lp(irq_lp), .mode_cur(mode_cur),
  .cpu_clk_sel(cpu_clk_sel), .mclk_sel(mclk_sel), .ulp_clk_sel(ulp_clk_sel),
  .tmr_clk_sel(tmr_clk_sel), .hfosc_en(hfosc_en), .periph_clk_en(periph_clk_en),
  .reg_drive(reg_drive), .pwr_off(pwr_off)
);

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  localparam int NREQ = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] mode_sel = '0;
  logic sleep_req = 0, irq_any = 0, irq_lp = 0, io_wake = 0, rst_pin_wake = 0, dbg_wake = 0;
  logic [NREQ-1:0] fclk_req = '0;
  logic [3:0] mode_cur;
  logic [1:0] cpu_clk_sel, mclk_sel, ulp_clk_sel, tmr_clk_sel, reg_drive;
  logic hfosc_en, pwr_off;
  logic [NREQ-1:0] periph_clk_en;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  lpm_ctrl #(.NREQ(NREQ)) dut (.*);

  // {mode[14:11], cpu[10:9], mclk[8:7], ulp[6:5], tmr[4:3], hfosc[2], reg[1:0]}, entered from RUN0
  localparam logic [14:0] VEC [12] = '{
    {4'd0,  2'd3, 2'd3, 2'd3, 2'd3, 1'b1, 2'd3},
    {4'd1,  2'd1, 2'd1, 2'd1, 2'd1, 1'b1, 2'd3},
    {4'd2,  2'd1, 2'd1, 2'd1, 2'd1, 1'b0, 2'd3},
    {4'd3,  2'd0, 2'd3, 2'd3, 2'd3, 1'b1, 2'd3},
    {4'd4,  2'd0, 2'd1, 2'd1, 2'd1, 1'b1, 2'd3},
    {4'd5,  2'd0, 2'd1, 2'd1, 2'd1, 1'b0, 2'd3},
    {4'd6,  2'd0, 2'd0, 2'd2, 2'd2, 1'b1, 2'd2},
    {4'd7,  2'd0, 2'd0, 2'd2, 2'd2, 1'b0, 2'd2},
    {4'd8,  2'd0, 2'd0, 2'd1, 2'd1, 1'b0, 2'd2},
    {4'd9,  2'd0, 2'd0, 2'd0, 2'd1, 1'b0, 2'd1},
    {4'd10, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0, 2'd1},
    {4'd11, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] ms, input logic sr, input logic ia, input logic il,
                      input logic io, input logic rp, input logic dw);
    @(negedge clk);
    mode_sel = ms; sleep_req = sr; irq_any = ia; irq_lp = il;
    io_wake = io; rst_pin_wake = rp; dbg_wake = dw;
    @(negedge clk);
    sleep_req = 0; irq_any = 0; irq_lp = 0; io_wake = 0; rst_pin_wake = 0; dbg_wake = 0;
  endtask

  task automatic go(input logic [3:0] ms);
    step(ms, 1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode", mode_cur, 0);
    chk("R1 cpu", cpu_clk_sel, 3);
    chk("R1 mclk", mclk_sel, 3);
    chk("R1 hfosc", hfosc_en, 1);
    chk("R1 reg", reg_drive, 2'd3);
    chk("R1 pwr_off", pwr_off, 0);
    chk("R1 periph", periph_clk_en, 4'hF);

    for (int i = 0; i < 12; i++) begin
      logic [14:0] v;
      int m;
      v = VEC[i];
      m = int'(v[14:11]);
      go(v[14:11]);
      chk(m <= 2 ? "R2 mode" : "R3 mode", mode_cur, m);
      chk("R2/R4/R5/R7/R8 cpu", cpu_clk_sel, v[10:9]);
      chk("R2/R4/R5/R7/R8 mclk", mclk_sel, v[8:7]);
      chk("R5/R7/R8 ulp", ulp_clk_sel, v[6:5]);
      chk("R5/R7/R8 tmr", tmr_clk_sel, v[4:3]);
      chk("R4/R5/R6 hfosc", hfosc_en, v[2]);
      chk("R5/R7/R8 reg", reg_drive, v[1:0]);
      chk("R8 pwr_off", pwr_off, m == 11);
      chk("R12 periph", periph_clk_en, m <= 8 ? 4'hF : 4'h0);
      if (m <= 2)      go(4'd0);
      else if (m <= 5) step(0, 0, 1, 0, 0, 0, 0);
      else if (m <= 10) step(0, 0, 0, 1, 0, 0, 0);
      else             step(0, 0, 0, 0, 1, 0, 0);
      chk("R10 back to RUN0", mode_cur, 0);
    end

    // R6 / R10: STOP0 depends on the entry run level
    go(4'd1); go(4'd6);
    chk("R6 from RUN1 hfosc", hfosc_en, 1);
    chk("R6 from RUN1 ulp", ulp_clk_sel, 1);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R10 back to RUN1", mode_cur, 1);
    go(4'd2); go(4'd6);
    chk("R6 from RUN2 hfosc", hfosc_en, 0);
    chk("R6 from RUN2 ulp", ulp_clk_sel, 1);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R10 back to RUN2", mode_cur, 2);
    go(4'd4);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R9 sleep wakes on irq_lp", mode_cur, 2);

    // R11: shutdown wake always lands in RUN0
    go(4'd11);
    step(0, 0, 1, 1, 0, 0, 0);
    chk("R11 irq ignored in shutdown", mode_cur, 11);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R11 reset pin wake", mode_cur, 0);
    go(4'd11);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R11 debug wake", mode_cur, 0);

    // R9: STOP ignores irq_any alone
    go(4'd7);
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R9 stop ignores irq_any", mode_cur, 7);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R9 stop wakes on irq_lp", mode_cur, 0);

    // R3: invalid code and request outside run are ignored
    go(4'd13);
    chk("R3 invalid code ignored", mode_cur, 0);
    go(4'd3);
    go(4'd8);
    chk("R3 request in sleep ignored", mode_cur, 3);
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R3 wake after ignored req", mode_cur, 0);

    // R12: fast-clock request in STANDBY1
    go(4'd10);
    fclk_req = 4'b0010;
    @(negedge clk);
    chk("R12 after one edge", periph_clk_en, 4'h0);
    @(negedge clk);
    chk("R12 after two edges", periph_clk_en, 4'b0010);
    chk("R12 mode unchanged", mode_cur, 10);
    fclk_req = 4'b0000;
    @(negedge clk);
    chk("R12 hold one edge", periph_clk_en, 4'b0010);
    @(negedge clk);
    chk("R12 released", periph_clk_en, 4'h0);
    step(0, 0, 0, 1, 0, 0, 0);
    go(4'd9);
    fclk_req = 4'b1001;
    repeat (3) @(negedge clk);
    chk("R12 STANDBY0 ignores request", periph_clk_en, 4'h0);
    chk("R12 STANDBY0 mode", mode_cur, 9);
    fclk_req = 4'b0000;
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R10 back from STANDBY0", mode_cur, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule